// File: doc/BRIEF.md
# Floating-Point Exception Signaling Controller

This block sits beside the instruction issue path of a floating-point unit. It classifies every floating-point instruction offered for issue. The instruction either traps because the coprocessor is disabled, traps because its opcode is undefined, is held back because an earlier numeric error has not yet been handled, or is accepted. It also keeps track of unmasked numeric errors reported when instructions complete. It drives an active-low error line meant for an input of an external interrupt controller. That controller in turn raises the processor's interrupt request.

Issue uses a valid/stall handshake. The source raises `iss_valid` with the opcode-defined flag and the two disable bits. When `iss_stall` is high in the same cycle, the offer is not taken. The source must then keep `iss_valid` and its fields stable, and the block evaluates the offer again in every following cycle. When `iss_stall` is low, the offer is consumed at that clock edge. The parameter `DEFER_ERR` selects when the error line drops. With 0, it drops as soon as the faulting instruction completes. With 1, it drops only when the next defined floating-point instruction is held by the pending error.

Top module: `fpx_sig_ctrl`

## Requirements
- R1: Synchronous active-high reset leaves `err_n` high, `trap_valid` low, `trap_vec` zero and `iss_stall` low, with no error pending.
- R2: An issue offer with `ctl_ts` or `ctl_em` set raises `trap_valid` with `trap_vec` = 7 one cycle later. This holds whether the opcode is defined or not and whether an error is pending or not, and such an offer never stalls.
- R3: An issue offer with both disable bits clear and `op_defined` low raises `trap_valid` with `trap_vec` = 6 one cycle later. It never stalls, and it does not change the pending error or the error line.
- R4: `trap_valid` is high for exactly one cycle per trapping offer, and `trap_vec` is zero in every cycle where `trap_valid` is low.
- R5: A completion (`done_valid`) with any bit of `done_flags` set makes an error pending. A completion with all flags zero does not.
- R6: With `DEFER_ERR` = 0, `err_n` goes low in the cycle after a completion with any flag set.
- R7: A defined opcode offered with disable bits clear while an error is pending sees `iss_stall` high in that same cycle. The stall lasts until the cycle after `err_ack`, after which the offer is accepted without a trap.
- R8: `err_ack` clears the pending error, and `err_n` is high in the following cycle unless a new flagged completion arrives in that same cycle.
- R9: With `DEFER_ERR` = 1, a flagged completion leaves `err_n` high. `err_n` goes low in the cycle after a defined opcode is held by the pending error.
- R10: When `err_ack` and a flagged completion occur in the same cycle, the error remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A floating-point instruction is offered for issue |
| iss_stall | output | 1 | Offer not taken this cycle; hold it stable |
| op_defined | input | 1 | The offered opcode is a defined floating-point opcode |
| ctl_ts | input | 1 | Task-switched disable bit |
| ctl_em | input | 1 | Emulate disable bit |
| done_valid | input | 1 | An instruction completes this cycle |
| done_flags | input | NFLAG | Unmasked numeric exception flags of the completing instruction |
| err_ack | input | 1 | The error handler has serviced the pending error |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_vec | output | 8 | Trap vector number, zero when no trap |
| err_n | output | 1 | Active-low error line toward the interrupt controller |

## Verification
Issue offers are tried with each disable bit alone, with both bits set, with a defined opcode and with an undefined one. These cases separate the disable check from the opcode check and show which of the two wins. The same offers are repeated while an error is pending. This shows that only defined, enabled opcodes stall, and that undefined opcodes do not touch the error line. Completions with zero flags, a single flag and a flag arriving together with the acknowledge separate the set rule from the clear rule. Two copies, one per `DEFER_ERR` setting, driven by identical stimulus, show when the error line drops in each mode.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    ISS_IDLE   = 2'd0,
    ISS_ACCEPT = 2'd1,
    ISS_HOLD   = 2'd2,
    ISS_TRAP   = 2'd3
  } iss_act_e;

  localparam int unsigned VEC_W = 8;
  localparam logic [VEC_W-1:0] VEC_DEV_NA = 8'd7;
  localparam logic [VEC_W-1:0] VEC_BAD_OP = 8'd6;
endpackage

// File: rtl/fpx_issue_dec.sv
module fpx_issue_dec
  import fpx_pkg::*;
(
  input  logic             iss_valid,
  input  logic             op_defined,
  input  logic             ctl_ts,
  input  logic             ctl_em,
  input  logic             pend,
  output iss_act_e         act,
  output logic [VEC_W-1:0] vec
);
  logic disabled;
  assign disabled = ctl_ts | ctl_em;

  // Priority: coprocessor disabled, then undefined opcode, then pending error.
  always_comb begin
    act = ISS_IDLE;
    vec = '0;
    if (iss_valid) begin
      if (disabled) begin
        act = ISS_TRAP;
        vec = VEC_DEV_NA;
      end else if (!op_defined) begin
        act = ISS_TRAP;
        vec = VEC_BAD_OP;
      end else if (pend) begin
        act = ISS_HOLD;
      end else begin
        act = ISS_ACCEPT;
      end
    end
  end
endmodule

// File: rtl/fpx_pend_trk.sv
module fpx_pend_trk #(
  parameter int unsigned NFLAG     = 6,
  parameter bit          DEFER_ERR = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_valid,
  input  logic [NFLAG-1:0] done_flags,
  input  logic             err_ack,
  input  logic             held,
  output logic             pend,
  output logic             err_n
);
  logic new_err;
  assign new_err = done_valid & (|done_flags);

  // A fresh error wins over a simultaneous acknowledge.
  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (new_err) pend <= 1'b1;
    else if (err_ack) pend <= 1'b0;
  end

  generate
    if (DEFER_ERR) begin : g_defer
      logic err_hold;
      always_ff @(posedge clk) begin
        if (rst)          err_hold <= 1'b0;
        else if (err_ack) err_hold <= 1'b0;
        else if (held)    err_hold <= 1'b1;
      end
      assign err_n = ~err_hold;
    end else begin : g_immed
      assign err_n = ~pend;
    end
  endgenerate
endmodule

// File: rtl/fpx_trap_out.sv
module fpx_trap_out
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  iss_act_e         act,
  input  logic [VEC_W-1:0] vec,
  output logic             trap_valid,
  output logic [VEC_W-1:0] trap_vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid <= 1'b0;
      trap_vec   <= '0;
    end else if (act == ISS_TRAP) begin
      trap_valid <= 1'b1;
      trap_vec   <= vec;
    end else begin
      trap_valid <= 1'b0;
      trap_vec   <= '0;
    end
  end
endmodule

// File: rtl/fpx_sig_ctrl.sv
module fpx_sig_ctrl
  import fpx_pkg::*;
#(
  parameter int unsigned NFLAG     = 6,
  parameter bit          DEFER_ERR = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  output logic             iss_stall,
  input  logic             op_defined,
  input  logic             ctl_ts,
  input  logic             ctl_em,
  input  logic             done_valid,
  input  logic [NFLAG-1:0] done_flags,
  input  logic             err_ack,
  output logic             trap_valid,
  output logic [7:0]       trap_vec,
  output logic             err_n
);
  iss_act_e         act;
  logic [VEC_W-1:0] dec_vec;
  logic             pend;

  fpx_issue_dec u_dec (
    .iss_valid  (iss_valid),
    .op_defined (op_defined),
    .ctl_ts     (ctl_ts),
    .ctl_em     (ctl_em),
    .pend       (pend),
    .act        (act),
    .vec        (dec_vec)
  );

  fpx_pend_trk #(.NFLAG(NFLAG), .DEFER_ERR(DEFER_ERR)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .done_valid (done_valid),
    .done_flags (done_flags),
    .err_ack    (err_ack),
    .held       (act == ISS_HOLD),
    .pend       (pend),
    .err_n      (err_n)
  );

  fpx_trap_out u_trap (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .vec        (dec_vec),
    .trap_valid (trap_valid),
    .trap_vec   (trap_vec)
  );

  assign iss_stall = (act == ISS_HOLD);
endmodule

// File: rtl/fpx_sig_ctrl_chk.sv
module fpx_sig_ctrl_chk #(
  parameter int unsigned NFLAG     = 6,
  parameter bit          DEFER_ERR = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_stall,
  input logic             op_defined,
  input logic             ctl_ts,
  input logic             ctl_em,
  input logic             done_valid,
  input logic [NFLAG-1:0] done_flags,
  input logic             err_ack,
  input logic             trap_valid,
  input logic [7:0]       trap_vec,
  input logic             err_n
);
  // R2: disable bits give vector 7 and never stall
  a_r2_disable_trap: assert property (@(posedge clk) disable iff (rst)
    iss_valid && (ctl_ts || ctl_em) |=> trap_valid && trap_vec == 8'd7);
  a_r2_disable_nostall: assert property (@(posedge clk) disable iff (rst)
    iss_valid && (ctl_ts || ctl_em) |-> !iss_stall);
  // R3: undefined opcode gives vector 6 and never stalls
  a_r3_undef_trap: assert property (@(posedge clk) disable iff (rst)
    iss_valid && !ctl_ts && !ctl_em && !op_defined |=> trap_valid && trap_vec == 8'd6);
  a_r3_undef_nostall: assert property (@(posedge clk) disable iff (rst)
    iss_valid && !op_defined |-> !iss_stall);
  // R4: vector is zero outside a trap pulse
  a_r4_vec_zero: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |-> trap_vec == 8'd0);
  // R7: a held offer does not trap
  a_r7_hold_notrap: assert property (@(posedge clk) disable iff (rst)
    iss_stall |=> !trap_valid);
  // R6: immediate mode drops the error line after a flagged completion
  a_r6_immed_err: assert property (@(posedge clk) disable iff (rst)
    !DEFER_ERR && done_valid && (|done_flags) |=> !err_n);
  // R8: acknowledge releases the error line
  a_r8_ack_release: assert property (@(posedge clk) disable iff (rst)
    err_ack && !(done_valid && (|done_flags)) |=> err_n);
  // R1: reset state
  a_r1_reset: assert property (@(posedge clk)
    rst |=> err_n && !trap_valid && trap_vec == 8'd0);
endmodule

bind fpx_sig_ctrl fpx_sig_ctrl_chk #(.NFLAG(NFLAG), .DEFER_ERR(DEFER_ERR)) u_chk (.*);

// File: tb/fpx_sig_ctrl_bench.sv
`timescale 1ns/1ps
module fpx_sig_ctrl_bench;
  localparam int unsigned NFLAG = 6;

  logic             clk = 1'b0;
  logic             rst;
  logic             iss_valid, op_defined, ctl_ts, ctl_em;
  logic             done_valid, err_ack;
  logic [NFLAG-1:0] done_flags;
  logic             stall_i, tv_i, errn_i;
  logic [7:0]       vec_i;
  logic             stall_d, tv_d, errn_d;
  logic [7:0]       vec_d;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fpx_sig_ctrl #(.NFLAG(NFLAG), .DEFER_ERR(1'b0)) u_fpx_sig_ctrl (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_stall(stall_i),
    .op_defined(op_defined), .ctl_ts(ctl_ts), .ctl_em(ctl_em),
    .done_valid(done_valid), .done_flags(done_flags), .err_ack(err_ack),
    .trap_valid(tv_i), .trap_vec(vec_i), .err_n(errn_i));

  fpx_sig_ctrl #(.NFLAG(NFLAG), .DEFER_ERR(1'b1)) u_fpx_sig_ctrl_dfr (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_stall(stall_d),
    .op_defined(op_defined), .ctl_ts(ctl_ts), .ctl_em(ctl_em),
    .done_valid(done_valid), .done_flags(done_flags), .err_ack(err_ack),
    .trap_valid(tv_d), .trap_vec(vec_d), .err_n(errn_d));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    iss_valid = 0; op_defined = 1; ctl_ts = 0; ctl_em = 0;
    done_valid = 0; done_flags = '0; err_ack = 0;
  endtask

  task automatic offer(input logic def, input logic ts, input logic em);
    iss_valid = 1; op_defined = def; ctl_ts = ts; ctl_em = em;
  endtask

  task automatic raise_err(input logic [NFLAG-1:0] f);
    done_valid = 1; done_flags = f;
    step();
    done_valid = 0; done_flags = '0;
  endtask

  task automatic do_ack();
    err_ack = 1;
    step();
    err_ack = 0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst = 1;
    step(); step();
    rst = 0;
    chk("R1 err_n", errn_i, 1);
    chk("R1 trap_valid", tv_i, 0);
    chk("R1 trap_vec", vec_i, 0);
    chk("R1 stall", stall_i, 0);
    chk("R1 err_n dfr", errn_d, 1);
  endtask

  task automatic t_disable(input logic def, input logic ts, input logic em, input string tag);
    offer(def, ts, em);
    #1 chk({"R2 nostall ", tag}, stall_i, 0);
    step();
    iss_valid = 0;
    chk({"R2 valid ", tag}, tv_i, 1);
    chk({"R2 vec ", tag}, vec_i, 7);
    step();
    chk({"R4 pulse end ", tag}, tv_i, 0);
    chk({"R4 vec zero ", tag}, vec_i, 0);
    idle_inputs();
  endtask

  task automatic t_undef(input string tag);
    offer(0, 0, 0);
    #1 chk({"R3 nostall ", tag}, stall_i, 0);
    step();
    iss_valid = 0;
    chk({"R3 valid ", tag}, tv_i, 1);
    chk({"R3 vec ", tag}, vec_i, 6);
    step();
    chk({"R4 pulse end ", tag}, tv_i, 0);
    idle_inputs();
  endtask

  task automatic t_clean();
    raise_err('0);
    chk("R5 zero flags keep err_n", errn_i, 1);
    offer(1, 0, 0);
    #1 chk("R5 zero flags no stall", stall_i, 0);
    step();
    iss_valid = 0;
    chk("R7 accept no trap", tv_i, 0);
    idle_inputs();
  endtask

  task automatic t_err_flow();
    raise_err(6'b000100);
    chk("R6 immed err_n low", errn_i, 0);
    chk("R9 dfr err_n still high", errn_d, 1);
    // undefined and disabled offers while pending
    t_undef("pending");
    chk("R3 err_n kept imm", errn_i, 0);
    chk("R3 no err dfr", errn_d, 1);
    t_disable(1, 1, 0, "pending");
    // defined offer is held
    offer(1, 0, 0);
    #1 chk("R7 stall imm", stall_i, 1);
    chk("R7 stall dfr", stall_d, 1);
    step();
    chk("R9 dfr err_n low after hold", errn_d, 0);
    chk("R7 stall persists", stall_i, 1);
    chk("R7 no trap while held", tv_i, 0);
    step();
    chk("R7 stall persists 2", stall_i, 1);
    do_ack();
    chk("R8 err_n high imm", errn_i, 1);
    chk("R8 err_n high dfr", errn_d, 1);
    chk("R7 stall released", stall_i, 0);
    chk("R7 stall released dfr", stall_d, 0);
    step();
    iss_valid = 0;
    chk("R7 accepted no trap", tv_i, 0);
    idle_inputs();
  endtask

  task automatic t_collide();
    raise_err(6'b000001);
    err_ack = 1; done_valid = 1; done_flags = 6'b100000;
    step();
    idle_inputs();
    chk("R10 still pending err_n", errn_i, 0);
    offer(1, 0, 0);
    #1 chk("R10 still stalls", stall_i, 1);
    iss_valid = 0;
    do_ack();
    chk("R8 cleared after collide", errn_i, 1);
    idle_inputs();
  endtask

  initial begin
    rst = 1;
    idle_inputs();
    step();
    t_reset();
    t_disable(1, 1, 0, "ts");
    t_disable(1, 0, 1, "em");
    t_disable(0, 1, 1, "undef both");
    t_undef("clean");
    t_clean();
    t_err_flow();
    t_collide();
    step();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule